// File: doc/BRIEF.md
# Multi-Plane Video Memory Access Unit

This block is the processor-side access path into a bit-planed video memory built from four byte-wide planes. A processor byte address that falls in the video window is turned into one plane offset, and that offset is used at the same byte position in every plane the access involves. A write can land in several planes at once. A read either returns one plane's byte or, in colour-search mode, returns a mask marking the pixels of that byte whose plane bits all match a target colour.

A small register set controls the unit. A write-format register picks the planes and the write mode. A read-format register picks the planes or target colour and the read mode. A mode register sets the display layout, and that layout fixes which planes exist. A window register sets the size of the processor window. A scroll offset and a start/end pair define a region of the window that is rotated by the offset. The planes are held in the block as four synchronous arrays. Picture refresh is not part of this block.

Top module: `vplane_access`

## Requirements
- R1: Synchronous active-low reset clears every register: write and read formats 0, mode field 0, narrow window, scroll offset 0, scroll start and end 0. Reset also drops `rd_valid`. Plane contents are not reset.
- R2: An address hits the window when it is at least 0x8000 and no higher than 0x9FFF. When the wide bit is set, the upper limit becomes 0xBFFF. The wide bit is bit 2 of the data written to select 3. The window offset is the address minus 0x8000, and the plane offset is its low PLANE_AW bits. An access outside the window writes nothing and never raises `rd_valid`.
- R3: In plain write mode, `cpu_wdata` goes to every plane i whose bit i is set in the write-format colour field (write format is select 0: bit 7 selects replace mode, bit 4 is the plane-pair flag, bits 3:0 are the colour/plane field). When mode bit 1 is set, the field is first ANDed with 0101b.
- R4: In replace write mode, each plane enabled by the mode mask receives `cpu_wdata` if its colour bit is 1 and 0x00 if its colour bit is 0. Planes outside the mask keep their contents.
- R5: The mode field is bits 2:1 of the data written to select 2, and it sets the mode mask. Value 00 gives planes {0,1}, or {2,3} when the flag is set. Value 01 gives all four planes. Value 10 gives plane 0, or plane 2 when the flag is set. Value 11 gives planes {0,2}.
- R6: A read with read-format bit 7 clear returns the byte of the lowest-numbered plane enabled by both the mode mask and read-format bits 3:0, or 0x00 if no plane qualifies. The read format is select 1, and its flag is bit 4. `rd_valid` and `cpu_rdata` appear in the cycle after the read is accepted.
- R7: A read with read-format bit 7 set returns a byte whose bit k is 1 exactly when every plane i in the mode mask has bit k equal to read-format bit i.
- R8: The scroll window is [start, end), given in window-offset bytes. An offset inside it has the scroll offset added, and the result wraps back by (end − start) when it reaches end. Offsets outside the window are used unchanged. This holds for scroll offsets no larger than the window length.
- R9: The start (select 6) and end (select 7) registers count in units of 128 bytes when the wide bit is set and in units of 64 bytes otherwise.
- R10: A register write and a processor access in the same cycle: the access uses the register values from before the write, and the new value governs from the next cycle.
- R11: The 10-bit scroll offset takes its low byte from select 4 and its upper two bits from bits 1:0 of select 5. Writing either part leaves the other part unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 write format, 1 read format, 2 mode, 3 window, 4 scroll low, 5 scroll high, 6 scroll start, 7 scroll end) |
| reg_data | input | 8 | Register write data |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe (ignored while cpu_wr is high) |
| cpu_wdata | input | 8 | Processor write data |
| cpu_hit | output | 1 | Address lies in the video window |
| rd_valid | output | 1 | Read result valid, one cycle after an accepted read |
| cpu_rdata | output | 8 | Read result |

## Verification
A register update and a processor access can fall on the same clock edge. Because the format and mode registers sit directly in the write-mask and read-select paths, the ordering at that edge is the interesting case. The bench provokes it by strobing a write-format change together with a processor write, and a read-format change together with a processor read. It then judges the outcome by reading every plane at that offset back, and by comparing the captured read against a reference model that still holds the old format. Both sides are also checked across mode, flag and colour sweeps and across scroll placements that wrap.

// File: rtl/vplane_pkg.sv
// Shared types for the multi-plane video memory access unit.
// Assumes exactly four planes; the mode-to-plane table is fixed by the layout.
package vplane_pkg;

    localparam int NPLANES = 4;

    typedef enum logic [2:0] {
        SEL_WFMT      = 3'd0,
        SEL_RFMT      = 3'd1,
        SEL_MODE      = 3'd2,
        SEL_WIN       = 3'd3,
        SEL_SCR_LO    = 3'd4,
        SEL_SCR_HI    = 3'd5,
        SEL_SCR_START = 3'd6,
        SEL_SCR_END   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic                wr_replace;
        logic                wr_flag;
        logic [NPLANES-1:0]  wr_col;
        logic                rd_search;
        logic                rd_flag;
        logic [NPLANES-1:0]  rd_col;
        logic [1:0]          mode;
        logic                wide;
        logic [9:0]          scroll;
        logic [7:0]          sstart;
        logic [7:0]          send;
    } vp_cfg_t;

    // Planes that exist for a given layout code and plane-pair flag.
    function automatic logic [NPLANES-1:0] mode_planes(input logic [1:0] mode,
                                                       input logic flag);
        case (mode)
            2'b00:   mode_planes = flag ? 4'b1100 : 4'b0011;
            2'b01:   mode_planes = 4'b1111;
            2'b10:   mode_planes = flag ? 4'b0100 : 4'b0001;
            default: mode_planes = 4'b0101;
        endcase
    endfunction

endpackage

// File: rtl/vplane_regs.sv
// Control register file: decodes register writes into the configuration struct.
// Assumes one register write per cycle; all fields reset to zero.
module vplane_regs
    import vplane_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [2:0] reg_sel,
    input  logic [7:0] reg_data,
    output vp_cfg_t    cfg
);

    // Register update; a write takes effect on the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (reg_wr) begin
            case (reg_sel_e'(reg_sel))
                SEL_WFMT: begin
                    cfg.wr_replace <= reg_data[7];
                    cfg.wr_flag    <= reg_data[4];
                    cfg.wr_col     <= reg_data[3:0];
                end
                SEL_RFMT: begin
                    cfg.rd_search <= reg_data[7];
                    cfg.rd_flag   <= reg_data[4];
                    cfg.rd_col    <= reg_data[3:0];
                end
                SEL_MODE:      cfg.mode         <= reg_data[2:1];
                SEL_WIN:       cfg.wide         <= reg_data[2];
                SEL_SCR_LO:    cfg.scroll[7:0]  <= reg_data;
                SEL_SCR_HI:    cfg.scroll[9:8]  <= reg_data[1:0];
                SEL_SCR_START: cfg.sstart       <= reg_data;
                default:       cfg.send         <= reg_data;
            endcase
        end
    end

    // R11: the upper scroll bits never disturb the low byte.
    a_r11_scroll_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_SCR_HI) |=> (cfg.scroll[7:0] == $past(cfg.scroll[7:0])));

    // R10: a written colour field is visible exactly one cycle later.
    a_r10_wfmt_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_WFMT) |=> (cfg.wr_col == $past(reg_data[3:0])));

endmodule

// File: rtl/vplane_xlate.sv
// Window decode and scroll translation of a processor address into a plane offset.
// Assumes the scroll offset does not exceed the scroll window length.
module vplane_xlate
    import vplane_pkg::*;
#(
    parameter int          PLANE_AW       = 9,
    parameter logic [15:0] WIN_BASE       = 16'h8000,
    parameter int          NARROW_SPAN_LG = 13,
    parameter int          WIDE_SPAN_LG   = 14,
    parameter int          UNIT_NARROW_LG = 6,
    parameter int          UNIT_WIDE_LG   = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [15:0]         cpu_addr,
    input  vp_cfg_t             cfg,
    output logic                hit,
    output logic [PLANE_AW-1:0] plane_addr
);

    localparam int XW = 17;

    logic [XW-1:0] ofs, lim, s_lo, s_hi, span, sum, tr;
    logic          in_win;

    // Window test, scroll window bounds and wrapped translation.
    always_comb begin
        ofs    = {1'b0, cpu_addr} - {1'b0, WIN_BASE};
        lim    = cfg.wide ? (XW'(1) << WIDE_SPAN_LG) : (XW'(1) << NARROW_SPAN_LG);
        hit    = (cpu_addr >= WIN_BASE) && (ofs < lim);
        s_lo   = cfg.wide ? ({9'd0, cfg.sstart} << UNIT_WIDE_LG)
                          : ({9'd0, cfg.sstart} << UNIT_NARROW_LG);
        s_hi   = cfg.wide ? ({9'd0, cfg.send} << UNIT_WIDE_LG)
                          : ({9'd0, cfg.send} << UNIT_NARROW_LG);
        span   = s_hi - s_lo;
        in_win = (ofs >= s_lo) && (ofs < s_hi);
        sum    = ofs + {7'd0, cfg.scroll};
        if (!in_win)
            tr = ofs;
        else if (sum >= s_hi)
            tr = sum - span;
        else
            tr = sum;
        plane_addr = tr[PLANE_AW-1:0];
    end

    // R8: a translated offset from inside the scroll window stays inside it.
    a_r8_stays_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && in_win && ({7'd0, cfg.scroll} <= span)) |-> ((tr >= s_lo) && (tr < s_hi)));

endmodule

// File: rtl/vplane_bank.sv
// Plane storage: one synchronous byte array per plane, shared offset.
// Assumes write and read are not requested together; read data is registered.
module vplane_bank
    import vplane_pkg::*;
#(
    parameter int PLANE_AW = 9
) (
    input  logic                           clk,
    input  logic [NPLANES-1:0]             we,
    input  logic [NPLANES-1:0][7:0]        wbytes,
    input  logic [PLANE_AW-1:0]            addr,
    input  logic                           rd_en,
    output logic [NPLANES-1:0][7:0]        rq
);

    localparam int DEPTH = 1 << PLANE_AW;

    for (genvar g = 0; g < NPLANES; g++) begin : g_plane
        logic [7:0] mem [DEPTH];
        logic [7:0] q;

        // Byte write and registered read for this plane.
        always_ff @(posedge clk) begin
            if (we[g])
                mem[addr] <= wbytes[g];
            if (rd_en)
                q <= mem[addr];
        end

        assign rq[g] = q;
    end

endmodule

// File: rtl/vplane_rdfmt.sv
// Read formatter: direct plane select or colour-search mask over captured bytes.
// Assumes mask, colour and mode were captured together with the plane bytes.
module vplane_rdfmt
    import vplane_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid,
    input  logic                    search,
    input  logic [NPLANES-1:0]      mask,
    input  logic [NPLANES-1:0]      color,
    input  logic [NPLANES-1:0][7:0] planes,
    output logic [7:0]              rdata
);

    logic [NPLANES-1:0] sel;
    logic               found;
    logic               bit_ok;

    // Result build: per-pixel colour match, or first qualifying plane.
    always_comb begin
        sel    = mask & color;
        rdata  = 8'h00;
        found  = 1'b0;
        bit_ok = 1'b0;
        if (search) begin
            for (int k = 0; k < 8; k++) begin
                bit_ok = 1'b1;
                for (int i = 0; i < NPLANES; i++)
                    if (mask[i] && (planes[i][k] != color[i]))
                        bit_ok = 1'b0;
                rdata[k] = bit_ok;
            end
        end else begin
            for (int i = 0; i < NPLANES; i++) begin
                if (sel[i] && !found) begin
                    rdata = planes[i];
                    found = 1'b1;
                end
            end
        end
    end

    // R7: with one plane enabled, search equals that plane, inverted for colour 0.
    a_r7_single_plane_search: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && search && mask == 4'b0001) |-> (rdata == (planes[0] ^ {8{~color[0]}})));

    // R6: a direct read with no qualifying plane returns zero.
    a_r6_direct_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !search && (mask & color) == '0) |-> (rdata == 8'h00));

endmodule

// File: rtl/vplane_access.sv
// Top of the multi-plane video memory access unit: register file, address
// translation, write fan-out, plane storage and read formatting.
// Assumes one processor access per cycle; a write masks a simultaneous read.
module vplane_access
    import vplane_pkg::*;
#(
    parameter int          PLANE_AW       = 9,
    parameter logic [15:0] WIN_BASE       = 16'h8000,
    parameter int          NARROW_SPAN_LG = 13,
    parameter int          WIDE_SPAN_LG   = 14,
    parameter int          UNIT_NARROW_LG = 6,
    parameter int          UNIT_WIDE_LG   = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_sel,
    input  logic [7:0]  reg_data,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_wr,
    input  logic        cpu_rd,
    input  logic [7:0]  cpu_wdata,
    output logic        cpu_hit,
    output logic        rd_valid,
    output logic [7:0]  cpu_rdata
);

    vp_cfg_t                 cfg;
    logic                    hit;
    logic [PLANE_AW-1:0]     paddr;
    logic [NPLANES-1:0]      wmask, we;
    logic [NPLANES-1:0][7:0] wbytes;
    logic [NPLANES-1:0][7:0] rq;
    logic                    do_rd;
    logic                    rd_search;
    logic [NPLANES-1:0]      rd_mask, rd_color;

    vplane_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_sel  (reg_sel),
        .reg_data (reg_data),
        .cfg      (cfg)
    );

    vplane_xlate #(
        .PLANE_AW       (PLANE_AW),
        .WIN_BASE       (WIN_BASE),
        .NARROW_SPAN_LG (NARROW_SPAN_LG),
        .WIDE_SPAN_LG   (WIDE_SPAN_LG),
        .UNIT_NARROW_LG (UNIT_NARROW_LG),
        .UNIT_WIDE_LG   (UNIT_WIDE_LG)
    ) u_xlate (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cfg        (cfg),
        .hit        (hit),
        .plane_addr (paddr)
    );

    // Write fan-out: plane set and per-plane byte for plain or replace mode.
    always_comb begin
        if (cfg.wr_replace) begin
            wmask = mode_planes(cfg.mode, cfg.wr_flag);
            for (int i = 0; i < NPLANES; i++)
                wbytes[i] = cfg.wr_col[i] ? cpu_wdata : 8'h00;
        end else begin
            wmask = cfg.mode[1] ? (cfg.wr_col & 4'b0101) : cfg.wr_col;
            for (int i = 0; i < NPLANES; i++)
                wbytes[i] = cpu_wdata;
        end
        we    = (cpu_wr && hit) ? wmask : '0;
        do_rd = cpu_rd && !cpu_wr && hit;
    end

    vplane_bank #(.PLANE_AW(PLANE_AW)) u_bank (
        .clk    (clk),
        .we     (we),
        .wbytes (wbytes),
        .addr   (paddr),
        .rd_en  (do_rd),
        .rq     (rq)
    );

    // Read capture: freeze read format and mode mask alongside the plane bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_search <= 1'b0;
            rd_mask   <= '0;
            rd_color  <= '0;
        end else begin
            rd_valid <= do_rd;
            if (do_rd) begin
                rd_search <= cfg.rd_search;
                rd_mask   <= mode_planes(cfg.mode, cfg.rd_flag);
                rd_color  <= cfg.rd_col;
            end
        end
    end

    vplane_rdfmt u_rdfmt (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (rd_valid),
        .search (rd_search),
        .mask   (rd_mask),
        .color  (rd_color),
        .planes (rq),
        .rdata  (cpu_rdata)
    );

    assign cpu_hit = hit;

    // R2: nothing is written for an address outside the window.
    a_r2_no_write_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit) |-> (we == '0));

    // R6: a result is presented only after an accepted in-window read.
    a_r6_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cpu_rd && !cpu_wr && hit));

    // R3: a plain write never reaches a plane absent from the colour field.
    a_r3_plain_within_field: assert property (@(posedge clk) disable iff (!rst_n)
        ((we != '0) && !cfg.wr_replace) |-> ((we & ~cfg.wr_col) == '0));

endmodule

// File: tb/sim_vplane_access.sv
`timescale 1ns/1ps
module sim_vplane_access;

    localparam int DEPTH = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  reg_data = '0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_hit;
    logic        rd_valid;
    logic [7:0]  cpu_rdata;

    int n_chk = 0;
    int n_fail = 0;

    // Shadow registers and plane model
    int b_wf = 0, b_rf = 0, b_mode = 0, b_wide = 0, b_sof = 0, b_ss = 0, b_se = 0;
    int mdl [4][DEPTH];

    always #5 clk = ~clk;

    vplane_access u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_data(reg_data), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_hit(cpu_hit),
        .rd_valid(rd_valid), .cpu_rdata(cpu_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic void shadow_update(input int sel, input int d);
        case (sel)
            0: b_wf = d;
            1: b_rf = d;
            2: b_mode = (d >> 1) & 3;
            3: b_wide = (d >> 2) & 1;
            4: b_sof = (b_sof & 'h300) | (d & 'hff);
            5: b_sof = (b_sof & 'hff) | ((d & 3) << 8);
            6: b_ss = d;
            default: b_se = d;
        endcase
    endfunction

    function automatic int mplanes(input int mode, input int flag);
        case (mode)
            0: return flag ? 'hC : 'h3;
            1: return 'hF;
            2: return flag ? 'h4 : 'h1;
            default: return 'h5;
        endcase
    endfunction

    function automatic bit in_range(input int addr);
        return addr >= 'h8000 && addr <= (b_wide ? 'hBFFF : 'h9FFF);
    endfunction

    function automatic int phys(input int addr);
        int ofs = addr - 'h8000;
        int unit = b_wide ? 128 : 64;
        int s = b_ss * unit;
        int e = b_se * unit;
        int t = ofs;
        if (ofs >= s && ofs < e) begin
            t = ofs + b_sof;
            if (t >= e) t = t - (e - s);
        end
        return t % DEPTH;
    endfunction

    function automatic void model_write(input int addr, input int d);
        int p, m;
        if (!in_range(addr)) return;
        p = phys(addr);
        if (b_wf & 'h80) begin
            m = mplanes(b_mode, (b_wf >> 4) & 1);
            for (int i = 0; i < 4; i++)
                if ((m >> i) & 1) mdl[i][p] = ((b_wf >> i) & 1) ? d : 0;
        end else begin
            m = b_wf & 'hF;
            if (b_mode & 2) m = m & 5;
            for (int i = 0; i < 4; i++)
                if ((m >> i) & 1) mdl[i][p] = d;
        end
    endfunction

    function automatic int exp_read(input int addr);
        int p = phys(addr);
        int m = mplanes(b_mode, (b_rf >> 4) & 1);
        int c = b_rf & 'hF;
        int r = 0;
        if (b_rf & 'h80) begin
            for (int k = 0; k < 8; k++) begin
                bit ok = 1;
                for (int i = 0; i < 4; i++)
                    if (((m >> i) & 1) && (((mdl[i][p] >> k) & 1) != ((c >> i) & 1))) ok = 0;
                if (ok) r = r | (1 << k);
            end
            return r;
        end
        for (int i = 0; i < 4; i++)
            if ((((m & c) >> i) & 1)) return mdl[i][p];
        return 0;
    endfunction

    task automatic setreg(input int sel, input int d);
        reg_wr = 1'b1; reg_sel = 3'(sel); reg_data = 8'(d);
        tick();
        reg_wr = 1'b0;
        shadow_update(sel, d);
    endtask

    task automatic cpu_write(input int addr, input int d);
        cpu_wr = 1'b1; cpu_addr = 16'(addr); cpu_wdata = 8'(d);
        tick();
        cpu_wr = 1'b0;
        model_write(addr, d);
    endtask

    task automatic rd_check(input int addr, input string req);
        int e;
        cpu_rd = 1'b1; cpu_addr = 16'(addr);
        tick();
        cpu_rd = 1'b0;
        e = exp_read(addr);
        chk(rd_valid === 1'b1 && int'(cpu_rdata) == e, req, int'(cpu_rdata), e);
    endtask

    task automatic rd_none(input int addr, input string req);
        cpu_rd = 1'b1; cpu_addr = 16'(addr);
        tick();
        cpu_rd = 1'b0;
        chk(rd_valid === 1'b0, req, int'(rd_valid), 0);
    endtask

    // Read back all four planes at one physical offset (scroll must be off there).
    task automatic verify_addr(input int p, input string req);
        setreg(2, 'h02);
        for (int i = 0; i < 4; i++) begin
            setreg(1, 1 << i);
            rd_check('h8000 + p, req);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog act=0 exp=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int d;
        repeat (3) tick();
        chk(rd_valid === 1'b0, "R1 rd_valid in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        tick();
        // R1: read format resets to 0, so a direct read returns 0x00
        rd_check('h8000, "R1 reset read format");
        // R1/R2: narrow window after reset
        rd_none('hA000, "R1 narrow window after reset");

        // R3/R6: fill each plane separately, then read all back
        setreg(2, 'h02);
        for (int p = 0; p < 4; p++) begin
            setreg(0, 1 << p);
            for (int a = 0; a < DEPTH; a++) cpu_write('h8000 + a, (a * 7 + p * 61 + (a >> 3)) & 'hFF);
        end
        for (int p = 0; p < 4; p++) begin
            setreg(1, 1 << p);
            for (int a = 0; a < DEPTH; a++) rd_check('h8000 + a, "R3 R6 plane fill");
        end

        // R5/R6: mode mask x flag x read field at one offset
        for (int m = 0; m < 4; m++)
            for (int f = 0; f < 2; f++)
                for (int c = 0; c < 16; c++) begin
                    setreg(2, m << 1);
                    setreg(1, (f << 4) | c);
                    rd_check('h8000 + 5, "R5 R6 mode mask direct");
                end

        // R7: colour search over modes, flags, colours and offsets
        for (int m = 0; m < 4; m++)
            for (int f = 0; f < 2; f++) begin
                setreg(2, m << 1);
                for (int c = 0; c < 16; c++) begin
                    setreg(1, 'h80 | (f << 4) | c);
                    for (int a = 0; a < 24; a++) rd_check('h8000 + a * 19, "R7 search");
                end
            end

        // R3: plain write masked to 0101b when mode bit 1 is set
        setreg(2, 'h04);
        setreg(0, 'h0F);
        cpu_write('h8000 + 100, 'hA5);
        verify_addr(100, "R3 plain masked");
        setreg(2, 'h00);
        setreg(0, 'h0F);
        cpu_write('h8000 + 101, 'h5A);
        verify_addr(101, "R3 plain unmasked");

        // R4: replace writes over modes, flags, colours
        for (int m = 0; m < 4; m++)
            for (int f = 0; f < 2; f++)
                for (int ci = 0; ci < 4; ci++) begin
                    int col = (ci == 0) ? 'h5 : (ci == 1) ? 'hA : (ci == 2) ? 'hF : 'h3;
                    int a = 200 + m * 8 + f * 4 + ci;
                    setreg(2, m << 1);
                    setreg(0, 'h80 | (f << 4) | col);
                    cpu_write('h8000 + a, 'hC3 ^ a);
                    verify_addr(a, "R4 replace");
                end

        // R2: window limits
        setreg(2, 'h02);
        setreg(0, 'h0F);
        cpu_write('h7FFF, 'hEE);
        cpu_write('hA000, 'hEE);
        verify_addr(0, "R2 outside writes ignored");
        verify_addr(511, "R2 outside writes ignored");
        rd_none('h7FFF, "R2 below window");
        setreg(3, 'h04);
        rd_none('hC000, "R2 above wide window");
        setreg(0, 'h0F);
        cpu_write('hBFFF, 'h77);
        setreg(1, 'h01);
        rd_check('hBFFF, "R2 wide window top");
        verify_addr(511, "R2 wide write");

        // R8/R9: narrow scroll window [64,192), offset 10
        setreg(3, 'h00);
        setreg(6, 1); setreg(7, 3); setreg(4, 10); setreg(5, 0);
        setreg(0, 'h0F);
        cpu_write('h8000 + 70, 'h11);
        cpu_write('h8000 + 190, 'h22);
        cpu_write('h8000 + 30, 'h33);
        cpu_write('h8000 + 192, 'h44);
        setreg(2, 'h02); setreg(1, 'h01);
        rd_check('h8000 + 190, "R8 read through wrap");
        // R9: wide units, window [128,256), offset 5
        setreg(3, 'h04);
        setreg(6, 1); setreg(7, 2); setreg(4, 5);
        setreg(0, 'h0F);
        cpu_write('h8000 + 254, 'h55);
        // R11: split offset 0x105 over a wide [0,4096) window
        setreg(6, 0); setreg(7, 'h20); setreg(4, 5); setreg(5, 1);
        cpu_write('h8000 + 100, 'h66);
        setreg(5, 0);
        cpu_write('h8000 + 101, 'h67);
        setreg(4, 0); setreg(7, 0); setreg(3, 0);
        verify_addr(80, "R8 in-window shift");
        verify_addr(72, "R8 wrap at end");
        verify_addr(30, "R8 outside untouched");
        verify_addr(192, "R8 end is exclusive");
        verify_addr(131, "R9 wide unit");
        verify_addr(361, "R11 high scroll bits");
        verify_addr(106, "R11 low byte kept");

        // R10: register write and processor write on the same edge
        setreg(2, 'h02);
        setreg(0, 'h01);
        reg_wr = 1'b1; reg_sel = 3'd0; reg_data = 8'h02;
        cpu_wr = 1'b1; cpu_addr = 16'h8000 + 16'd300; cpu_wdata = 8'h3C;
        tick();
        reg_wr = 1'b0; cpu_wr = 1'b0;
        model_write('h8000 + 300, 'h3C);
        shadow_update(0, 'h02);
        cpu_write('h8000 + 301, 'h4D);
        verify_addr(300, "R10 write uses old format");
        verify_addr(301, "R10 new format next cycle");
        // R10: register write and processor read on the same edge
        setreg(1, 'h01);
        reg_wr = 1'b1; reg_sel = 3'd1; reg_data = 8'h02;
        cpu_rd = 1'b1; cpu_addr = 16'h8000 + 16'd300;
        tick();
        reg_wr = 1'b0; cpu_rd = 1'b0;
        d = exp_read('h8000 + 300);
        chk(rd_valid === 1'b1 && int'(cpu_rdata) == d, "R10 read uses old format", int'(cpu_rdata), d);
        shadow_update(1, 'h02);
        rd_check('h8000 + 300, "R10 read new format");

        // Final sweep of every plane and offset
        setreg(2, 'h02);
        for (int p = 0; p < 4; p++) begin
            setreg(1, 1 << p);
            for (int a = 0; a < DEPTH; a++) rd_check('h8000 + a, "R3 R4 final contents");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule